// File: doc/BRIEF.md
# Preset Ring Counter with Two-Tap OR Output

This block is a closed loop of N single-bit D-type stages. Every stage passes its value to the next stage on each rising clock edge, and the last stage hands its value back to the first. A synchronous reset loads a fixed preset pattern into the loop. Once reset is released, the pattern keeps circulating with no further control.

The output bit is the OR of two chosen stage outputs. With the default preset and tap choices, this produces a repeating waveform that is richer than a plain divided clock. If the preset holds a single one and both taps name the same stage, the output is a clock divided by N.

The ring length, the preset pattern and the two tap positions are parameters. The full loop contents are brought out on an observation bus. Stage k (counted 1 to N in the shift direction) appears on bit k-1 of that bus.

Top module: `preset_ring_counter`

## Requirements
- R1: On each rising clock edge with reset inactive, stage k+1 takes the previous value of stage k, and stage 1 takes the previous value of stage N (ring_state becomes {ring_state[N-2:0], ring_state[N-1]}).
- R2: Reset loads PRESET into the ring. The default (N=6) sets stages 2 and 5 and clears the rest, so ring_state = 6'b010010.
- R3: Reset is synchronous and active low. While rst_n is held low across several edges, the ring stays at PRESET and does not shift.
- R4: f_out is the OR of stage TAP_A and stage TAP_B. The defaults are stages 2 and 4, i.e. ring_state[1] | ring_state[3].
- R5: f_out is formed combinationally from the registered stages. It is valid in the same cycle as the ring_state value it derives from and changes only after clock edges.
- R6: After release the pattern circulates without any further input. After every N shifts ring_state equals PRESET again.
- R7: Driving rst_n low in the middle of a run restores PRESET on the next rising edge, whatever the ring held.
- R8: With reset inactive, the number of ones in the ring is constant.
- R9: With a single-one preset and both taps on the same stage, f_out is high for exactly one cycle in every N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| rst_n | input | 1 | Synchronous active-low reset; loads PRESET |
| f_out | output | 1 | OR of stages TAP_A and TAP_B |
| ring_state | output | N | Ring contents; bit k-1 is stage k |

## Verification
Reset loads the ring on the first rising edge after rst_n is low. Each shift lands on the rising edge it follows. f_out adds no register, so it changes with ring_state in that same cycle. The bench drives rst_n on falling edges and samples both outputs on the next falling edge, half a period after the edge that updated them. Each expected value comes from a bench-side rotation model that is advanced once per edge.

// File: rtl/ring_pkg.sv
// Package: shared helpers for the ring counter.
// Assumes stage indices are 0-based bit positions in the ring vector.
package ring_pkg;
    // Index of the stage that feeds stage idx in a ring of n stages.
    function automatic int unsigned ring_src_idx(input int unsigned idx, input int unsigned n);
        return (idx == 0) ? n - 1 : idx - 1;
    endfunction
endpackage

// File: rtl/ring_stage.sv
// Module: one D-type stage of the ring.
// Loads INIT_VAL on a synchronous active-low reset, otherwise captures d.
module ring_stage #(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Capture the upstream stage, or the preset bit during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= INIT_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/ring_tap_or.sv
// Module: combinational OR of two selected ring stages.
// Assumes TAP_A and TAP_B are 1-based stage numbers within 1..N.
module ring_tap_or #(
    parameter int unsigned N     = 6,
    parameter int unsigned TAP_A = 2,
    parameter int unsigned TAP_B = 4
) (
    input  logic [N-1:0] stages,
    output logic         y
);
    localparam int unsigned IDX_A = TAP_A - 1;
    localparam int unsigned IDX_B = TAP_B - 1;

    // Merge the two tapped stages into one output bit.
    always_comb y = stages[IDX_A] | stages[IDX_B];
endmodule

// File: rtl/preset_ring_counter.sv
// Module: preset ring counter with a two-tap OR output.
// N stages form a closed loop. Reset loads PRESET (bit k-1 = stage k).
// f_out is the OR of stages TAP_A and TAP_B.
// Assumes N >= 2 and tap numbers within 1..N.
module preset_ring_counter #(
    parameter int unsigned N          = 6,
    parameter logic [N-1:0] PRESET    = 6'b010010,
    parameter int unsigned TAP_A      = 2,
    parameter int unsigned TAP_B      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic         f_out,
    output logic [N-1:0] ring_state
);
    import ring_pkg::*;

    logic [N-1:0] stage_q;

    // One stage per ring position, each fed by its upstream neighbour.
    for (genvar i = 0; i < N; i++) begin : g_stage
        localparam int unsigned SRC = ring_src_idx(i, N);
        ring_stage #(.INIT_VAL(PRESET[i])) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (stage_q[SRC]),
            .q    (stage_q[i])
        );
    end

    ring_tap_or #(.N(N), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_tap (
        .stages(stage_q),
        .y     (f_out)
    );

    // Expose the full ring contents.
    always_comb ring_state = stage_q;
endmodule

// File: rtl/ring_counter_chk.sv
// Module: property checker for preset_ring_counter, attached by bind.
// Properties are armed only after one reset edge has been seen.
module ring_counter_chk #(
    parameter int unsigned N       = 6,
    parameter logic [N-1:0] PRESET = 6'b010010,
    parameter int unsigned TAP_A   = 2,
    parameter int unsigned TAP_B   = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         f_out,
    input logic [N-1:0] ring_state
);
    logic armed;
    logic was_reset;

    // Note that a reset edge has occurred, and whether the last edge was reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b1;
            was_reset <= 1'b1;
        end else begin
            was_reset <= 1'b0;
        end
    end

    // R2
    preset_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1 && was_reset === 1'b1) |-> ring_state == PRESET);

    // R1
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1 && was_reset === 1'b0) |->
        ring_state == {$past(ring_state[N-2:0]), $past(ring_state[N-1])});

    // R8
    ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1) |-> $countones(ring_state) == $countones(PRESET));

    // R4
    low_out_taps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed === 1'b1 && !f_out) |-> (!ring_state[TAP_A-1] && !ring_state[TAP_B-1]));
endmodule

bind preset_ring_counter ring_counter_chk #(
    .N(N), .PRESET(PRESET), .TAP_A(TAP_A), .TAP_B(TAP_B)
) u_ring_chk (
    .clk(clk), .rst_n(rst_n), .f_out(f_out), .ring_state(ring_state)
);

// File: tb/tb_preset_ring_counter.sv
`timescale 1ns/1ps
module tb_preset_ring_counter;
    localparam int unsigned N = 6;
    localparam logic [N-1:0] PRE = 6'b010010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_out, f_div;
    logic [N-1:0] ring_state, div_state;
    int unsigned n_run = 0, n_fail = 0;
    logic [N-1:0] model;

    always #2.5 clk = ~clk;

    preset_ring_counter dut (.clk(clk), .rst_n(rst_n), .f_out(f_out), .ring_state(ring_state));

    preset_ring_counter #(.N(N), .PRESET(6'b000001), .TAP_A(1), .TAP_B(1)) dut_div (
        .clk(clk), .rst_n(rst_n), .f_out(f_div), .ring_state(div_state));

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] rot(input logic [N-1:0] s);
        return {s[N-2:0], s[N-1]};
    endfunction

    // Advance one edge and sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        step(); step();
        chk("R2 preset", ring_state, PRE);
        chk("R4 tap or at reset", {5'b0, f_out}, {5'b0, PRE[1] | PRE[3]});
    endtask

    task automatic test_hold_reset();
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 held reset", ring_state, PRE);
        end
    endtask

    task automatic test_rotation();
        rst_n = 1'b1;
        model = PRE;
        for (int c = 1; c <= 2 * N + 2; c++) begin
            step();
            model = rot(model);
            chk("R1 rotate", ring_state, model);
            chk("R4 R5 tap or", {5'b0, f_out}, {5'b0, model[1] | model[3]});
            chk("R8 ones", N'($countones(ring_state)), N'(2));
            if (c % N == 0) chk("R6 period", ring_state, PRE);
        end
    endtask

    task automatic test_mid_reset();
        step();
        rst_n = 1'b0;
        step();
        chk("R7 mid reset", ring_state, PRE);
        rst_n = 1'b1;
        step();
        chk("R7 resume", ring_state, rot(PRE));
    endtask

    task automatic test_divider();
        int unsigned highs = 0;
        int unsigned last = 0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R9 div preset", div_state, 6'b000001);
        for (int c = 1; c <= 3 * N; c++) begin
            step();
            if (f_div) begin
                if (highs > 0) chk("R9 spacing", N'(c - last), N'(N));
                highs++;
                last = c;
            end
        end
        chk("R9 high count", N'(highs), N'(3));
    endtask

    initial begin
        #(200000 * 5);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_hold_reset();
        test_rotation();
        test_mid_reset();
        test_divider();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule